// File: doc/BRIEF.md
# Accumulator Memory-Reference Sequencer

This block is the control path of a 16-bit processor with a single accumulator. It holds the program counter, the accumulator (AC) and a one-bit link. It fetches instruction words over a synchronous memory port. Memory-reference words run through a fetch, an optional pointer-resolution step (defer) and an execute step. Operands are addressed relative to the current 2K-word page. An indirect word first reads a pointer. Pointer cells at page offsets 0x08 to 0x0F advance by one before use, and the new value is written back.

Operate, shift and skip words are not executed here. They go to a separate operate unit through a request/done pair. That unit returns a new AC, a new link, a skip flag and a halt flag, and the sequencer then goes back to fetching. I/O-transfer words produce a one-cycle strobe that carries their 9-bit device/operation code. The sequencer comes out of reset halted, and a run strobe starts it.

Top module: `mref_seq`

## Requirements
- R1: After a synchronous reset, the state is as follows: PC = 0x0020, AC = 0, link = 0, and `halted_o` = 1.
- R2: While halted, the block issues no memory read, no memory write and no operate request. It ignores `mem_rvalid_i` and `op_done_i`. A one-cycle `run_i` starts fetching at PC.
- R3: The instruction word fields are: bit 15 is the indirect flag, bits 14:11 are the order code and bits 10:0 are the address field. The order codes are 1 = immediate load, 2 = jump, 4 = store AC, 5 = exchange, 6 = increment-and-skip-if-zero, 7 = subroutine call, 9 = AND, A = OR, B = XOR, C = load, D = add, E = subtract, F = skip-if-equal. An indirect word goes fetch, then defer, then execute. A direct word goes from fetch to execute.
- R4: The operand address is the PC page bits (PC[15:11], masked to the memory size) concatenated with the 11-bit field.
- R5: In defer, the pointer is read from the effective address. If the field is 0x08 to 0x0F, the pointer+1 is written back to that cell and used as the operand address. Offsets 0x07 and 0x10 are used unchanged.
- R6: Add complements the link on a carry out of bit 15. Subtract complements it on a borrow. Otherwise the link is unchanged.
- R7: AND, OR, XOR and load combine or replace AC with the memory word. Store writes AC to memory. Exchange swaps AC and the memory word.
- R8: Increment-and-skip writes memory+1 back and skips one word (PC += 2) when the result is 0. Skip-if-equal skips when AC equals the memory word.
- R9: Jump loads PC with the target. Subroutine call stores PC+1 at the target and continues at target+1.
- R10: Order code 1 loads the zero-extended field into AC. With bit 15 set, it loads the two's-complement negation of the field instead. It never runs a defer step.
- R11: A word with bits 15:9 = 0000001 is an I/O transfer. It pulses `iot_stb_o` for one cycle with bits 8:0 on `iot_code_o` and advances PC by 1. Code 0x030 produces no strobe.
- R12: A word is an operate-class word when it matches one of these patterns: bits 14:6 all zero, bits 15:9 = 0000011, or bits 14:9 = 000010. The block holds `op_req_o` with the word on `op_word_o` until `op_done_i`. It then takes `op_ac_i` and `op_link_i` and advances PC by 1 + `op_skip_i`. It halts if `op_halt_i` is set.
- R13: Each read holds its address and `mem_rd_o` until `mem_rvalid_i`, and PC stays unchanged while a fetch waits. Writes last one cycle with `mem_we_o`. A read and a write are never issued together.
- R14: A word matching none of these classes (order code 0, 3 or 8) does nothing except advance PC by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Start strobe, honoured only while halted |
| mem_addr_o | output | 16 | Memory word address |
| mem_rd_o | output | 1 | Read request, held until data is valid |
| mem_we_o | output | 1 | One-cycle write enable |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data |
| mem_rvalid_i | input | 1 | Read data valid pulse |
| op_req_o | output | 1 | Operate-unit request |
| op_word_o | output | 16 | Operate-class instruction word |
| op_done_i | input | 1 | Operate-unit completion |
| op_ac_i | input | 16 | New AC from operate unit |
| op_link_i | input | 1 | New link from operate unit |
| op_skip_i | input | 1 | Skip next word |
| op_halt_i | input | 1 | Halt after this word |
| iot_stb_o | output | 1 | I/O transfer strobe |
| iot_code_o | output | 9 | Device/operation code |
| pc_o | output | 16 | Program counter |
| ac_o | output | 16 | Accumulator |
| link_o | output | 1 | Link bit |
| halted_o | output | 1 | Sequencer is halted |

## Verification
Two functions fall in the same cycle when an I/O-transfer strobe is issued. That strobe coincides with the read request for the following word. Back-to-back transfer words, with a muted 0x030 code between them, provoke this. The bench judges it by counting exactly two strobes, checking their codes in order and checking the final PC.

A related collision happens on one memory cell. An increment-and-skip through auto-index cell 0x09 whose pointer points to cell 0x09 itself makes the pointer write-back and the operand read-modify-write touch the same cell. The bench judges it by the final value 0x000A in that cell.

// File: rtl/mref_pkg.sv
package mref_pkg;

    localparam int WORD_W  = 16;
    localparam int FIELD_W = 11;
    localparam int IOT_W   = 9;
    localparam logic [WORD_W-1:0] BOOT_PC  = 16'h0020;
    localparam logic [IOT_W-1:0]  IOT_MUTE = 9'h030;

    typedef enum logic [3:0] {
        OC_NONE = 4'h0,
        OC_IMM  = 4'h1,
        OC_JMP  = 4'h2,
        OC_DAC  = 4'h4,
        OC_XAM  = 4'h5,
        OC_ISZ  = 4'h6,
        OC_JMS  = 4'h7,
        OC_AND  = 4'h9,
        OC_IOR  = 4'hA,
        OC_XOR  = 4'hB,
        OC_LAC  = 4'hC,
        OC_ADD  = 4'hD,
        OC_SUB  = 4'hE,
        OC_SAM  = 4'hF
    } order_e;

    typedef enum logic [1:0] {
        K_VOID, K_OPER, K_IOT, K_ORDER
    } kind_e;

    typedef enum logic [2:0] {
        S_HALT, S_FETCH, S_DEFER, S_DWB, S_EXEC, S_WB, S_OPER
    } state_e;

    typedef struct packed {
        kind_e               kind;
        order_e              op;
        logic                ind;
        logic                neg;
        logic [FIELD_W-1:0]  field;
        logic [IOT_W-1:0]    iot;
    } dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] ac;
        logic              link;
        logic              skip;
        logic [WORD_W-1:0] store;
    } alu_t;

    function automatic logic reads_mem(order_e op);
        return op inside {OC_XAM, OC_ISZ, OC_AND, OC_IOR, OC_XOR,
                          OC_LAC, OC_ADD, OC_SUB, OC_SAM};
    endfunction

    function automatic logic rmw_op(order_e op);
        return op inside {OC_XAM, OC_ISZ};
    endfunction

endpackage

// File: rtl/mref_decode.sv
module mref_decode
    import mref_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o       = '0;
        dec_o.kind  = K_VOID;
        dec_o.op    = OC_NONE;
        dec_o.field = word_i[FIELD_W-1:0];
        dec_o.iot   = word_i[IOT_W-1:0];
        if (word_i[14:6] == 9'd0) begin
            dec_o.kind = K_OPER;
        end else if (word_i[15:9] == 7'b0000011) begin
            dec_o.kind = K_OPER;
        end else if (word_i[14:9] == 6'b000010) begin
            dec_o.kind = K_OPER;
        end else if (word_i[15:9] == 7'b0000001) begin
            dec_o.kind = K_IOT;
        end else begin
            case (word_i[14:11])
                4'h1: begin
                    dec_o.kind = K_ORDER;
                    dec_o.op   = OC_IMM;
                    dec_o.neg  = word_i[15];
                    dec_o.ind  = 1'b0;
                end
                4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'h9, 4'hA,
                4'hB, 4'hC, 4'hD, 4'hE, 4'hF: begin
                    dec_o.kind = K_ORDER;
                    dec_o.op   = order_e'(word_i[14:11]);
                    dec_o.ind  = word_i[15];
                end
                default: dec_o.kind = K_VOID;
            endcase
        end
    end
endmodule

// File: rtl/mref_addr.sv
module mref_addr
    import mref_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic [4:0]         page_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [WORD_W-1:0]  ea_o,
    output logic               idx_hit_o
);
    localparam logic [16:0]       SPAN    = 17'(1) << MEM_AW;
    localparam logic [WORD_W-1:0] AMASK   = 16'(SPAN - 17'd1);
    localparam logic [4:0]        PG_MASK = AMASK[15:11];

    assign ea_o      = {page_i & PG_MASK, field_i};
    assign idx_hit_o = (field_i[10:3] == 8'h01);
endmodule

// File: rtl/mref_alu.sv
module mref_alu
    import mref_pkg::*;
(
    input  order_e             op_i,
    input  logic               neg_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [WORD_W-1:0]  ac_i,
    input  logic               link_i,
    input  logic [WORD_W-1:0]  q_i,
    output alu_t               res_o
);
    logic [WORD_W:0]   sum, diff;
    logic [WORD_W-1:0] qinc, imm;

    assign sum  = {1'b0, ac_i} + {1'b0, q_i};
    assign diff = {1'b0, ac_i} - {1'b0, q_i};
    assign qinc = q_i + 16'd1;
    assign imm  = {5'd0, field_i};

    always_comb begin
        res_o.ac    = ac_i;
        res_o.link  = link_i;
        res_o.skip  = 1'b0;
        res_o.store = ac_i;
        case (op_i)
            OC_ADD: begin
                res_o.ac   = sum[WORD_W-1:0];
                res_o.link = link_i ^ sum[WORD_W];
            end
            OC_SUB: begin
                res_o.ac   = diff[WORD_W-1:0];
                res_o.link = link_i ^ diff[WORD_W];
            end
            OC_AND: res_o.ac = ac_i & q_i;
            OC_IOR: res_o.ac = ac_i | q_i;
            OC_XOR: res_o.ac = ac_i ^ q_i;
            OC_LAC: res_o.ac = q_i;
            OC_XAM: begin
                res_o.ac    = q_i;
                res_o.store = ac_i;
            end
            OC_ISZ: begin
                res_o.store = qinc;
                res_o.skip  = (qinc == 16'd0);
            end
            OC_SAM: res_o.skip = (ac_i == q_i);
            OC_IMM: res_o.ac = neg_i ? (16'd0 - imm) : imm;
            default: ;
        endcase
    end
endmodule

// File: rtl/mref_seq.sv
module mref_seq
    import mref_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    output logic [15:0]       mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_we_o,
    output logic [15:0]       mem_wdata_o,
    input  logic [15:0]       mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              op_req_o,
    output logic [15:0]       op_word_o,
    input  logic              op_done_i,
    input  logic [15:0]       op_ac_i,
    input  logic              op_link_i,
    input  logic              op_skip_i,
    input  logic              op_halt_i,
    output logic              iot_stb_o,
    output logic [8:0]        iot_code_o,
    output logic [15:0]       pc_o,
    output logic [15:0]       ac_o,
    output logic              link_o,
    output logic              halted_o
);
    state_e             st;
    logic [WORD_W-1:0]  pc_q, ac_q, ir_q, ptr_q, wb_q;
    logic               link_q;
    order_e             op_q;
    logic               ind_q, neg_q;
    logic [FIELD_W-1:0] field_q;

    dec_t               dec_w;
    alu_t               alu_w;
    logic [WORD_W-1:0]  ea_w, oa_w;
    logic               idx_w;

    mref_decode u_dec (.word_i(mem_rdata_i), .dec_o(dec_w));

    mref_addr #(.MEM_AW(MEM_AW)) u_addr (
        .page_i(pc_q[15:11]), .field_i(field_q),
        .ea_o(ea_w), .idx_hit_o(idx_w));

    mref_alu u_alu (
        .op_i(op_q), .neg_i(neg_q), .field_i(field_q),
        .ac_i(ac_q), .link_i(link_q), .q_i(mem_rdata_i), .res_o(alu_w));

    assign oa_w = ind_q ? ptr_q : ea_w;

    always_comb begin
        mem_rd_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = pc_q;
        mem_wdata_o = wb_q;
        case (st)
            S_FETCH: mem_rd_o = 1'b1;
            S_DEFER: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = ea_w;
            end
            S_DWB: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = ea_w;
                mem_wdata_o = ptr_q;
            end
            S_EXEC: begin
                mem_addr_o = oa_w;
                if (reads_mem(op_q)) begin
                    mem_rd_o = 1'b1;
                end else if (op_q == OC_DAC) begin
                    mem_we_o    = 1'b1;
                    mem_wdata_o = ac_q;
                end else if (op_q == OC_JMS) begin
                    mem_we_o    = 1'b1;
                    mem_wdata_o = pc_q + 16'd1;
                end
            end
            S_WB: begin
                mem_we_o   = 1'b1;
                mem_addr_o = ptr_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_HALT;
            pc_q       <= BOOT_PC;
            ac_q       <= '0;
            link_q     <= 1'b0;
            ir_q       <= '0;
            ptr_q      <= '0;
            wb_q       <= '0;
            op_q       <= OC_NONE;
            ind_q      <= 1'b0;
            neg_q      <= 1'b0;
            field_q    <= '0;
            iot_stb_o  <= 1'b0;
            iot_code_o <= '0;
        end else begin
            iot_stb_o <= 1'b0;
            case (st)
                S_HALT: if (run_i) st <= S_FETCH;
                S_FETCH: if (mem_rvalid_i) begin
                    ir_q    <= mem_rdata_i;
                    op_q    <= dec_w.op;
                    ind_q   <= dec_w.ind;
                    neg_q   <= dec_w.neg;
                    field_q <= dec_w.field;
                    case (dec_w.kind)
                        K_OPER:  st <= S_OPER;
                        K_IOT: begin
                            pc_q <= pc_q + 16'd1;
                            if (dec_w.iot != IOT_MUTE) begin
                                iot_stb_o  <= 1'b1;
                                iot_code_o <= dec_w.iot;
                            end
                        end
                        K_ORDER: st <= dec_w.ind ? S_DEFER : S_EXEC;
                        default: pc_q <= pc_q + 16'd1;
                    endcase
                end
                S_DEFER: if (mem_rvalid_i) begin
                    if (idx_w) begin
                        ptr_q <= mem_rdata_i + 16'd1;
                        st    <= S_DWB;
                    end else begin
                        ptr_q <= mem_rdata_i;
                        st    <= S_EXEC;
                    end
                end
                S_DWB: st <= S_EXEC;
                S_EXEC: begin
                    if (op_q == OC_JMP) begin
                        pc_q <= oa_w;
                        st   <= S_FETCH;
                    end else if (op_q == OC_JMS) begin
                        pc_q <= oa_w + 16'd1;
                        st   <= S_FETCH;
                    end else if (!reads_mem(op_q) || mem_rvalid_i) begin
                        ac_q   <= alu_w.ac;
                        link_q <= alu_w.link;
                        wb_q   <= alu_w.store;
                        ptr_q  <= oa_w;
                        pc_q   <= pc_q + 16'd1 + {15'd0, alu_w.skip};
                        st     <= rmw_op(op_q) ? S_WB : S_FETCH;
                    end
                end
                S_WB: st <= S_FETCH;
                S_OPER: if (op_done_i) begin
                    ac_q   <= op_ac_i;
                    link_q <= op_link_i;
                    pc_q   <= pc_q + 16'd1 + {15'd0, op_skip_i};
                    st     <= op_halt_i ? S_HALT : S_FETCH;
                end
                default: st <= S_HALT;
            endcase
        end
    end

    assign op_req_o  = (st == S_OPER);
    assign op_word_o = ir_q;
    assign pc_o      = pc_q;
    assign ac_o      = ac_q;
    assign link_o    = link_q;
    assign halted_o  = (st == S_HALT);

    // R13
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_we_o));

    // R13
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_FETCH && !mem_rvalid_i) |=> ($stable(pc_q) && st == S_FETCH));

    // R2
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |-> (!mem_rd_o && !mem_we_o && !op_req_o));

    // R11
    iot_mute_chk: assert property (@(posedge clk) disable iff (rst)
        iot_stb_o |-> (iot_code_o != IOT_MUTE));

    // R5
    idx_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_DWB) |-> (mem_we_o && mem_addr_o[10:3] == 8'h01));

    // R10
    imm_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_FETCH && mem_rvalid_i && dec_w.kind == K_ORDER && dec_w.op == OC_IMM)
        |=> (st == S_EXEC));
endmodule

// File: tb/sim_mref_seq.sv
`timescale 1ns/1ps
module sim_mref_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    always #2 clk = ~clk;

    logic [15:0] mem_addr, mem_wdata, mem_rdata, op_word, op_ac, pc, ac;
    logic mem_rd, mem_we, rv_m, op_req, od_m, op_link, op_skip, op_halt;
    logic iot_stb, link, halted;
    logic [8:0] iot_code;
    logic poke_rv = 1'b0, poke_od = 1'b0;
    logic rvalid, op_done;
    assign rvalid  = rv_m | poke_rv;
    assign op_done = od_m | poke_od;

    mref_seq u0 (
        .clk(clk), .rst(rst), .run_i(run),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_we_o(mem_we),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rvalid_i(rvalid),
        .op_req_o(op_req), .op_word_o(op_word), .op_done_i(op_done),
        .op_ac_i(op_ac), .op_link_i(op_link), .op_skip_i(op_skip), .op_halt_i(op_halt),
        .iot_stb_o(iot_stb), .iot_code_o(iot_code),
        .pc_o(pc), .ac_o(ac), .link_o(link), .halted_o(halted));

    logic [15:0] mem [0:4095];
    initial begin rv_m = 1'b0; od_m = 1'b0; mem_rdata = '0; op_ac = '0;
        op_link = 1'b0; op_skip = 1'b0; op_halt = 1'b0; end

    // memory model: data one cycle after request
    always @(posedge clk) begin
        rv_m      <= mem_rd && !rv_m;
        mem_rdata <= mem[mem_addr[11:0]];
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    // operate-unit stand-in: bit0 complements AC, bit1 skips, bit15 clear halts
    always @(posedge clk) begin
        od_m    <= op_req && !od_m;
        op_ac   <= op_word[0] ? ~ac : ac;
        op_link <= link;
        op_skip <= op_word[1];
        op_halt <= !op_word[15];
    end

    int iot_cnt = 0;
    logic [8:0] iot_first, iot_last;
    always @(negedge clk) if (!rst && iot_stb) begin
        if (iot_cnt == 0) iot_first = iot_code;
        iot_last = iot_code;
        iot_cnt++;
    end

    int checks = 0, errors = 0, cyc = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        iot_cnt = 0;
    endtask

    task automatic run_prog(input string tag);
        int n;
        @(negedge clk); run = 1'b1;
        @(negedge clk); run = 1'b0;
        n = 0;
        while (!halted && n < 2000) begin @(negedge clk); n++; end
        chk(halted, tag, 16'(n), 16'd2000);
    endtask

    typedef struct packed {
        logic [15:0] word, ac_in, m_in, ac_x;
        logic        lk_x;
        logic [15:0] pc_x, m_x;
    } vec_t;

    // word at 0x21 operates on cell 0x100; AC preloaded from 0x200
    localparam vec_t VEC [16] = '{
        '{16'h6900, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 16'h0023, 16'h0001}, // R6 carry
        '{16'h6900, 16'h1234, 16'h1111, 16'h2345, 1'b0, 16'h0023, 16'h1111}, // R6
        '{16'h7100, 16'h0001, 16'h0002, 16'hFFFF, 1'b1, 16'h0023, 16'h0002}, // R6 borrow
        '{16'h7100, 16'h0005, 16'h0003, 16'h0002, 1'b0, 16'h0023, 16'h0003}, // R6
        '{16'h4900, 16'hF0F0, 16'hFF00, 16'hF000, 1'b0, 16'h0023, 16'hFF00}, // R7
        '{16'h5100, 16'h00F0, 16'h0F00, 16'h0FF0, 1'b0, 16'h0023, 16'h0F00}, // R7
        '{16'h5900, 16'hFFFF, 16'h0F0F, 16'hF0F0, 1'b0, 16'h0023, 16'h0F0F}, // R7
        '{16'h2100, 16'hBEEF, 16'h0000, 16'hBEEF, 1'b0, 16'h0023, 16'hBEEF}, // R7
        '{16'h2900, 16'h1111, 16'h2222, 16'h2222, 1'b0, 16'h0023, 16'h1111}, // R7
        '{16'h3100, 16'h0007, 16'hFFFF, 16'h0007, 1'b0, 16'h0024, 16'h0000}, // R8
        '{16'h3100, 16'h0007, 16'h0005, 16'h0007, 1'b0, 16'h0023, 16'h0006}, // R8
        '{16'h7900, 16'h4444, 16'h4444, 16'h4444, 1'b0, 16'h0024, 16'h4444}, // R8
        '{16'h7900, 16'h4444, 16'h4445, 16'h4444, 1'b0, 16'h0023, 16'h4445}, // R8
        '{16'h0923, 16'h5555, 16'h0000, 16'h0123, 1'b0, 16'h0023, 16'h0000}, // R10
        '{16'h8801, 16'h5555, 16'h0000, 16'hFFFF, 1'b0, 16'h0023, 16'h0000}, // R10
        '{16'h8FFF, 16'h5555, 16'h0000, 16'hF801, 1'b0, 16'h0023, 16'h0000}  // R10
    };

    initial begin
        clear_mem();
        do_reset();
        // R1 reset state
        chk(pc == 16'h0020, "R1 pc", pc, 16'h0020);
        chk(ac == 16'h0000, "R1 ac", ac, 16'h0000);
        chk(link == 1'b0, "R1 link", {15'd0, link}, 16'h0000);
        chk(halted == 1'b1, "R1 halted", {15'd0, halted}, 16'h0001);

        // R2 stray handshakes while halted
        @(negedge clk); poke_rv = 1'b1; poke_od = 1'b1;
        repeat (3) @(negedge clk);
        poke_rv = 1'b0; poke_od = 1'b0;
        @(negedge clk);
        chk(halted && !mem_rd && !op_req, "R2 still halted", {15'd0, halted}, 16'h0001);
        chk(pc == 16'h0020 && ac == 16'h0000, "R2 state kept", pc, 16'h0020);

        // table walk: R6 R7 R8 R10 (R3 field layout, R13 handshake)
        foreach (VEC[i]) begin
            clear_mem();
            mem[12'h020] = 16'h6200;
            mem[12'h021] = VEC[i].word;
            mem[12'h100] = VEC[i].m_in;
            mem[12'h200] = VEC[i].ac_in;
            do_reset();
            run_prog("R13 vec run");
            chk(ac == VEC[i].ac_x, $sformatf("R7 vec%0d ac", i), ac, VEC[i].ac_x);
            chk(link == VEC[i].lk_x, $sformatf("R6 vec%0d link", i), {15'd0, link}, {15'd0, VEC[i].lk_x});
            chk(pc == VEC[i].pc_x, $sformatf("R8 vec%0d pc", i), pc, VEC[i].pc_x);
            chk(mem[12'h100] == VEC[i].m_x, $sformatf("R3 vec%0d mem", i), mem[12'h100], VEC[i].m_x);
        end

        // R9 jump
        clear_mem(); mem[12'h020] = 16'h1030; do_reset(); run_prog("R9 jmp");
        chk(pc == 16'h0031, "R9 jump pc", pc, 16'h0031);

        // R9 subroutine call
        clear_mem(); mem[12'h020] = 16'h3840; mem[12'h041] = 16'h0000;
        do_reset(); run_prog("R9 jms");
        chk(mem[12'h040] == 16'h0021, "R9 return cell", mem[12'h040], 16'h0021);
        chk(pc == 16'h0042, "R9 call pc", pc, 16'h0042);

        // R5 auto-index boundaries 0x07 0x08 0x0F 0x10
        foreach (VEC[k]) if (k < 4) begin
            logic [11:0] off;
            bit inc;
            off = (k == 0) ? 12'h007 : (k == 1) ? 12'h008 : (k == 2) ? 12'h00F : 12'h010;
            inc = (k == 1) || (k == 2);
            clear_mem();
            mem[12'h020] = 16'hE000 | {4'd0, off};
            mem[off] = 16'h02FF; mem[12'h2FF] = 16'h1111; mem[12'h300] = 16'h2222;
            do_reset(); run_prog("R5 run");
            chk(ac == (inc ? 16'h2222 : 16'h1111), $sformatf("R5 off%h ac", off), ac, inc ? 16'h2222 : 16'h1111);
            chk(mem[off] == (inc ? 16'h0300 : 16'h02FF), $sformatf("R5 off%h ptr", off), mem[off], inc ? 16'h0300 : 16'h02FF);
        end

        // R5 self-referencing index cell with increment-and-skip
        clear_mem(); mem[12'h020] = 16'hB009; mem[12'h009] = 16'h0008;
        do_reset(); run_prog("R5 self");
        chk(mem[12'h009] == 16'h000A, "R5 self cell", mem[12'h009], 16'h000A);
        chk(pc == 16'h0022, "R8 self pc", pc, 16'h0022);

        // R4 page-relative addressing via indirect jump to page 1
        clear_mem(); mem[12'h020] = 16'h9060; mem[12'h060] = 16'h0820;
        mem[12'h820] = 16'h6005; mem[12'h805] = 16'h5A5A; mem[12'h005] = 16'h1111;
        do_reset(); run_prog("R4 run");
        chk(ac == 16'h5A5A, "R4 page ac", ac, 16'h5A5A);
        chk(pc == 16'h0822, "R4 page pc", pc, 16'h0822);

        // R11 I/O transfers, muted code between two live ones
        clear_mem(); mem[12'h020] = 16'h0212; mem[12'h021] = 16'h0230; mem[12'h022] = 16'h0215;
        do_reset(); run_prog("R11 run");
        chk(iot_cnt == 2, "R11 strobe count", 16'(iot_cnt), 16'd2);
        chk(iot_first == 9'h012, "R11 first code", {7'd0, iot_first}, 16'h0012);
        chk(iot_last == 9'h015, "R11 last code", {7'd0, iot_last}, 16'h0015);
        chk(pc == 16'h0024, "R11 pc", pc, 16'h0024);

        // R12 operate handoff with skip
        clear_mem(); mem[12'h020] = 16'h8001; mem[12'h021] = 16'h8002;
        do_reset(); run_prog("R12 run");
        chk(ac == 16'hFFFF, "R12 ac", ac, 16'hFFFF);
        chk(pc == 16'h0024, "R12 pc", pc, 16'h0024);

        // R14 undefined order code
        clear_mem(); mem[12'h020] = 16'h4123; do_reset(); run_prog("R14 run");
        chk(pc == 16'h0022 && ac == 16'h0000, "R14 no-op pc", pc, 16'h0022);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule